// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a serial EEPROM that is driven over a chip-select / serial-clock / data-in link and answers on a data output that can be released. It runs on a fast system clock. The serial pins are synchronised and the rising edges of the serial clock are detected in the system clock domain. Every instruction begins with a start bit, then a two-bit opcode and an address field. It operates on an internal array that is stored as bytes. The array starts out erased, with every bit at one.

An organisation input picks one of two views of the same storage. With it high, the array holds 16-bit words and the address is one bit shorter. With it low, the array holds bytes. Word `a` is formed by byte `2a` as the upper half and byte `2a+1` as the lower half.

Modifying instructions are self-timed. Programming starts when chip select falls after a complete frame. The programming times are parameters counted in system clock cycles. While programming runs, raising chip select shows a low status bit. The status bit goes high once the array has been updated.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, `sdo_oe_o` is 0 and modifying instructions are disabled until a write-enable instruction arrives.
- R2: Zeros clocked in before the first 1 are ignored. A frame is that 1, a two-bit opcode (10 read, 01 write, 11 erase, 00 special) and an address field, each sampled MSB first on serial clock rising edges while chip select is high.
- R3: In 16-bit mode the address field is BYTE_AW-1 bits. A read drives a 0 after the last address bit, then the 16 data bits MSB first, one per serial clock rising edge. With the default parameters a one-word read takes 29 clocks and a header-only frame takes 13.
- R4: In 8-bit mode the address field is BYTE_AW bits and a read returns 8 bits after the dummy 0 (22 and 14 clocks at default). Byte `2a` is the upper half of 16-bit word `a`.
- R5: Extra clocks during a read shift out the following words in order. The address wraps from the last location to 0.
- R6: For opcode 00, the top two address bits select the operation: 11 enables modification, 00 disables it, 10 erases the whole array, 01 writes one value everywhere. While modification is disabled, write, erase, erase-all and write-all leave the array unchanged and start no programming.
- R7: While `pe_i` is low, write, erase, erase-all and write-all are ignored.
- R8: Erase sets the addressed location to all ones.
- R9: Erase-all sets every location to all ones.
- R10: Write-all sets every location to the supplied value, after an implicit erase-all.
- R11: With chip select high after programming has started, `sdo_oe_o` is 1. `sdo_o` is 0 while busy and 1 once programming is done. With chip select low, `sdo_oe_o` is 0.
- R12: Programming lasts T_WORD cycles for write and erase, T_ERAL for erase-all and T_WRAL for write-all, counted from the synchronised fall of chip select.
- R13: Start bits sent while programming is busy are ignored, so the whole frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock, sampled |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | 1: 16-bit words, 0: bytes |
| pe_i | input | 1 | Program enable, low blocks modification |
| sdo_o | output | 1 | Serial data / ready status |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |

## Verification
The bench builds the block with BYTE_AW=6, which gives 32 words or 64 bytes. The programming times are set to 400, 600 and 1200 cycles. These values make the address wrap on sequential reads, erase-all and write-all over the whole array, and the busy window measurable within a short run. The 400-cycle word time is longer than a full special-opcode frame, so the bench can issue an instruction in the middle of a programming cycle.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_ERAL, CMD_WRAL, CMD_EWEN, CMD_EWDS
  } cmd_e;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sck_rise_o,
  output logic cs_fall_o
);
  logic [2:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= {cs_i, sck_i, di_i};
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cs_o       = s2_q[2];
  assign di_o       = s2_q[0];
  assign sck_rise_o = s2_q[2] & s2_q[1] & ~s3_q[1];
  assign cs_fall_o  = ~s2_q[2] & s3_q[2];
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_eeprom_pkg::*;
#(
  parameter int BYTE_AW = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               sck_rise_i,
  input  logic               di_i,
  input  logic               x16_i,
  input  logic               hold_i,
  output logic               start_o,
  output logic               hdr_o,
  output logic               data_v_o,
  output cmd_e               cmd_o,
  output logic [BYTE_AW-1:0] addr_o,
  output logic [15:0]        wdata_o,
  output logic               rd_tick_o
);
  localparam int HW = BYTE_AW + 2;
  localparam int CW = $clog2((HW > 16 ? HW : 16) + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_HOLD} st_e;
  st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hsr_q, hnext;
  logic [1:0] op2, sub2;
  logic [BYTE_AW-1:0] addr_dec;
  cmd_e cmd_dec;

  assign hnext = {hsr_q[HW-2:0], di_i};

  always_comb begin
    op2      = x16_i ? hnext[HW-2 -: 2] : hnext[HW-1 -: 2];
    sub2     = x16_i ? hnext[HW-4 -: 2] : hnext[HW-3 -: 2];
    addr_dec = x16_i ? {1'b0, hnext[BYTE_AW-2:0]} : hnext[BYTE_AW-1:0];
    unique case (op2)
      2'b10: cmd_dec = CMD_READ;
      2'b01: cmd_dec = CMD_WRITE;
      2'b11: cmd_dec = CMD_ERASE;
      default: begin
        unique case (sub2)
          2'b11:   cmd_dec = CMD_EWEN;
          2'b10:   cmd_dec = CMD_ERAL;
          2'b01:   cmd_dec = CMD_WRAL;
          default: cmd_dec = CMD_EWDS;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      hsr_q    <= '0;
      start_o  <= 1'b0;
      hdr_o    <= 1'b0;
      data_v_o <= 1'b0;
      cmd_o    <= CMD_NONE;
      addr_o   <= '0;
      wdata_o  <= '0;
    end else begin
      start_o  <= 1'b0;
      hdr_o    <= 1'b0;
      data_v_o <= 1'b0;
      if (!cs_i) begin
        st_q <= S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE: if (sck_rise_i && di_i && !hold_i) begin
            st_q    <= S_HDR;
            cnt_q   <= '0;
            hsr_q   <= '0;
            start_o <= 1'b1;
          end
          S_HDR: if (sck_rise_i) begin
            hsr_q <= hnext;
            if (cnt_q == CW'(x16_i ? HW-2 : HW-1)) begin
              hdr_o  <= 1'b1;
              cmd_o  <= cmd_dec;
              addr_o <= addr_dec;
              cnt_q  <= '0;
              if (cmd_dec == CMD_READ) st_q <= S_READ;
              else if (cmd_dec == CMD_WRITE || cmd_dec == CMD_WRAL) st_q <= S_DATA;
              else st_q <= S_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: if (sck_rise_i) begin
            wdata_o <= {wdata_o[14:0], di_i};
            if (cnt_q == CW'(x16_i ? 15 : 7)) begin
              data_v_o <= 1'b1;
              st_q     <= S_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_tick_o = (st_q == S_READ) && cs_i && sck_rise_i;

  // R2
  hdr_data_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_o && data_v_o));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cycles_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= cycles_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end

  assign busy_o = (cnt_q != '0);

  // R13
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R12
  busy_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_eeprom_pkg::*;
#(
  parameter int BYTE_AW = 11,
  parameter int T_WORD  = 500000,
  parameter int T_ERAL  = 750000,
  parameter int T_WRAL  = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int DEPTH = 1 << BYTE_AW;
  localparam int TMAX  = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WORD) ? T_WRAL : T_WORD)
                                           : ((T_ERAL > T_WORD) ? T_ERAL : T_WORD);
  localparam int TW    = $clog2(TMAX + 1);

  logic cs_q, di_q, sck_rise, cs_fall;
  logic frm_start, frm_hdr, frm_dat, rd_tick;
  cmd_e frm_cmd;
  logic [BYTE_AW-1:0] frm_addr;
  logic [15:0] frm_data;
  logic busy, done, tmr_start;
  logic [TW-1:0] tmr_cycles;

  mw_pin_sync u_sync (
    .clk_i, .rst_ni, .cs_i, .sck_i, .di_i,
    .cs_o(cs_q), .di_o(di_q), .sck_rise_o(sck_rise), .cs_fall_o(cs_fall)
  );

  mw_frame_rx #(.BYTE_AW(BYTE_AW)) u_rx (
    .clk_i, .rst_ni, .cs_i(cs_q), .sck_rise_i(sck_rise), .di_i(di_q),
    .x16_i(org_i), .hold_i(busy), .start_o(frm_start), .hdr_o(frm_hdr),
    .data_v_o(frm_dat), .cmd_o(frm_cmd), .addr_o(frm_addr),
    .wdata_o(frm_data), .rd_tick_o(rd_tick)
  );

  mw_prog_timer #(.CW(TW)) u_tmr (
    .clk_i, .rst_ni, .start_i(tmr_start), .cycles_i(tmr_cycles),
    .busy_o(busy), .done_o(done)
  );

  // enable latch and pending command
  logic en_q, pend_q, pend_x16, prog_x16, stat_q;
  cmd_e pend_cmd, prog_cmd;
  logic [BYTE_AW-1:0] pend_addr, prog_addr;
  logic [15:0] pend_data, prog_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      pend_cmd  <= CMD_NONE;
      pend_addr <= '0;
      pend_data <= '0;
      pend_x16  <= 1'b0;
    end else begin
      if (frm_hdr && frm_cmd == CMD_EWEN) en_q <= 1'b1;
      if (frm_hdr && frm_cmd == CMD_EWDS) en_q <= 1'b0;
      if (frm_hdr && (frm_cmd == CMD_ERASE || frm_cmd == CMD_ERAL) && en_q && pe_i) begin
        pend_q    <= 1'b1;
        pend_cmd  <= frm_cmd;
        pend_addr <= frm_addr;
        pend_x16  <= org_i;
      end else if (frm_dat && en_q && pe_i) begin
        pend_q    <= 1'b1;
        pend_cmd  <= frm_cmd;
        pend_addr <= frm_addr;
        pend_data <= frm_data;
        pend_x16  <= org_i;
      end else if (cs_fall || frm_start) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign tmr_start = cs_fall && pend_q && !busy;
  always_comb begin
    unique case (pend_cmd)
      CMD_ERAL: tmr_cycles = TW'(T_ERAL);
      CMD_WRAL: tmr_cycles = TW'(T_WRAL);
      default:  tmr_cycles = TW'(T_WORD);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_cmd  <= CMD_NONE;
      prog_addr <= '0;
      prog_data <= '0;
      prog_x16  <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      if (tmr_start) begin
        prog_cmd  <= pend_cmd;
        prog_addr <= pend_addr;
        prog_data <= pend_data;
        prog_x16  <= pend_x16;
      end
      if (tmr_start) stat_q <= 1'b1;
      else if (frm_start) stat_q <= 1'b0;
    end
  end

  // byte array, committed when the programming time expires
  logic [7:0] mem [DEPTH];
  logic [BYTE_AW-1:0] pa_hi, pa_lo;
  assign pa_hi = {prog_addr[BYTE_AW-2:0], 1'b0};
  assign pa_lo = {prog_addr[BYTE_AW-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      unique case (prog_cmd)
        CMD_WRITE: begin
          if (prog_x16) begin
            mem[pa_hi] <= prog_data[15:8];
            mem[pa_lo] <= prog_data[7:0];
          end else begin
            mem[prog_addr] <= prog_data[7:0];
          end
        end
        CMD_ERASE: begin
          if (prog_x16) begin
            mem[pa_hi] <= 8'hFF;
            mem[pa_lo] <= 8'hFF;
          end else begin
            mem[prog_addr] <= 8'hFF;
          end
        end
        CMD_ERAL: for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        CMD_WRAL: for (int i = 0; i < DEPTH; i++)
          mem[i] <= (prog_x16 && i[0] == 1'b0) ? prog_data[15:8] : prog_data[7:0];
        default: ;
      endcase
    end
  end

  // read shifter
  logic [BYTE_AW-1:0] rd_addr, hdr_inc, rd_inc;
  logic [15:0] rd_sr, hdr_word, nxt_word;
  logic [3:0] rd_bit;
  logic rd_oe_q, do_q;

  always_comb begin
    hdr_word = org_i ? {mem[{frm_addr[BYTE_AW-2:0], 1'b0}], mem[{frm_addr[BYTE_AW-2:0], 1'b1}]}
                     : {mem[frm_addr], 8'h00};
    nxt_word = org_i ? {mem[{rd_addr[BYTE_AW-2:0], 1'b0}], mem[{rd_addr[BYTE_AW-2:0], 1'b1}]}
                     : {mem[rd_addr], 8'h00};
    hdr_inc = frm_addr + 1'b1;
    rd_inc  = rd_addr + 1'b1;
    if (org_i) begin
      hdr_inc[BYTE_AW-1] = 1'b0;
      rd_inc[BYTE_AW-1]  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_oe_q <= 1'b0;
      do_q    <= 1'b0;
      rd_sr   <= '0;
      rd_addr <= '0;
      rd_bit  <= '0;
    end else if (!cs_q) begin
      rd_oe_q <= 1'b0;
    end else if (frm_hdr && frm_cmd == CMD_READ) begin
      rd_oe_q <= 1'b1;
      do_q    <= 1'b0;
      rd_sr   <= hdr_word;
      rd_addr <= hdr_inc;
      rd_bit  <= '0;
    end else if (rd_tick) begin
      do_q <= rd_sr[15];
      if (rd_bit == (org_i ? 4'd15 : 4'd7)) begin
        rd_sr   <= nxt_word;
        rd_addr <= rd_inc;
        rd_bit  <= '0;
      end else begin
        rd_sr  <= {rd_sr[14:0], 1'b0};
        rd_bit <= rd_bit + 1'b1;
      end
    end
  end

  assign sdo_oe_o = cs_q && (rd_oe_q || stat_q);
  assign sdo_o    = rd_oe_q ? do_q : ~busy;

  // R13
  busy_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !rd_oe_q);
  // R6
  pend_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> en_q);
  // R11
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && cs_q && stat_q) |-> (sdo_o && sdo_oe_o));
endmodule

// File: tb/sim_mw_eeprom_slave.sv
`timescale 1ns/1ps
module sim_mw_eeprom_slave;
  localparam int AW = 6;
  localparam int TWD = 400;
  localparam int TER = 600;
  localparam int TWR = 1200;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
  logic sdo, oe;
  always #10 clk = ~clk;

  mw_eeprom_slave #(.BYTE_AW(AW), .T_WORD(TWD), .T_ERAL(TER), .T_WRAL(TWR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .org_i(org), .pe_i(pe), .sdo_o(sdo), .sdo_oe_o(oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [64];
  logic exp_q[$];
  string tag_q[$];
  int req_cnt = 0, ack_cnt = 0;
  bit finished = 0;

  // monitor: pops expected serial bits and compares
  always @(negedge clk) begin
    if (ack_cnt != req_cnt) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (!(oe === 1'b1 && sdo === e)) begin
        n_bad++;
        $display("FAIL %s: sdo=%b oe=%b expected sdo=%b oe=1", t, sdo, oe, e);
      end
      ack_cnt++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(logic b, bit ce, logic e, string t);
    di = b;
    cyc(HALF);
    sck = 1'b1;
    cyc(HALF);
    if (ce) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
      req_cnt++;
      wait (ack_cnt == req_cnt);
      #1;
    end
    sck = 1'b0;
  endtask

  task automatic cs_up();   cs = 1'b1; cyc(HALF); endtask
  task automatic cs_down(); sck = 1'b0; cs = 1'b0; cyc(HALF); endtask

  function automatic int abits(bit x16); return x16 ? AW-1 : AW; endfunction

  task automatic send_hdr(logic [1:0] op, logic [6:0] fld, bit x16, bit rd, string t);
    int n;
    n = abits(x16);
    tick(1'b1, 0, 1'b0, "");
    tick(op[1], 0, 1'b0, "");
    tick(op[0], 0, 1'b0, "");
    for (int i = n-1; i >= 0; i--) tick(fld[i], rd && i == 0, 1'b0, t);
  endtask

  function automatic logic [6:0] subf(logic [1:0] s, bit x16);
    return 7'(s) << (abits(x16) - 2);
  endfunction

  task automatic rd(int a, int nw, bit x16, int lead, string t);
    int ad;
    logic [15:0] w;
    cs_up();
    for (int i = 0; i < lead; i++) tick(1'b0, 0, 1'b0, "");
    send_hdr(2'b10, 7'(a), x16, 1, t);
    ad = a;
    for (int k = 0; k < nw; k++) begin
      w = x16 ? {mdl[2*ad], mdl[2*ad+1]} : {mdl[ad], 8'h00};
      for (int i = 0; i < (x16 ? 16 : 8); i++) tick(1'b0, 1, w[15-i], t);
      ad = (ad + 1) % (x16 ? 32 : 64);
    end
    cs_down();
  endtask

  task automatic instr(logic [1:0] op, logic [6:0] fld, bit x16, bit hd, logic [15:0] d);
    int nd;
    nd = x16 ? 16 : 8;
    cs_up();
    send_hdr(op, fld, x16, 0, "");
    if (hd) for (int i = nd-1; i >= 0; i--) tick(d[i], 0, 1'b0, "");
    cs_down();
  endtask

  task automatic wait_timed(int t, string tag);
    int k;
    k = 0;
    cs = 1'b1;
    cyc(HALF);
    chk(oe === 1'b1 && sdo === 1'b0, "R11 busy status", {oe, sdo}, 2'b10);
    while (sdo !== 1'b1 && k < 20000) begin cyc(1); k++; end
    chk((2*HALF + k >= t) && (2*HALF + k <= t + 6), tag, 2*HALF + k, t);
    chk(oe === 1'b1 && sdo === 1'b1, "R11 ready status", {oe, sdo}, 2'b11);
    cs = 1'b0;
    cyc(HALF);
    chk(oe === 1'b0, "R11 released with cs low", oe, 0);
  endtask

  task automatic no_prog(string tag);
    cs_up();
    chk(oe === 1'b0, tag, oe, 0);
    cs_down();
  endtask

  task automatic poll_ready();
    int k;
    k = 0;
    cs = 1'b1;
    cyc(HALF);
    while (sdo !== 1'b1 && k < 20000) begin cyc(1); k++; end
    cs = 1'b0;
    cyc(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    chk(oe === 1'b0, "R1 output released after reset", oe, 0);

    // R3 erased read, R2 leading zeros ignored
    rd(3, 1, 1, 2, "R2 R3 read after reset");

    // R1 R6 write before enable is ignored
    instr(2'b01, 7'd3, 1, 1, 16'hA5C3);
    no_prog("R6 no programming while disabled");
    rd(3, 1, 1, 0, "R6 disabled write left word");

    instr(2'b00, subf(2'b11, 1), 1, 0, 16'h0);
    instr(2'b01, 7'd3, 1, 1, 16'hA5C3);
    wait_timed(TWD, "R12 word write time");
    mdl[6] = 8'hA5; mdl[7] = 8'hC3;
    rd(3, 1, 1, 0, "R3 word read");

    // R5 sequential with wrap
    instr(2'b01, 7'd31, 1, 1, 16'h1234);
    poll_ready();
    mdl[62] = 8'h12; mdl[63] = 8'h34;
    instr(2'b01, 7'd0, 1, 1, 16'hBEEF);
    poll_ready();
    mdl[0] = 8'hBE; mdl[1] = 8'hEF;
    rd(30, 4, 1, 0, "R5 sequential wrap");

    // R7 program enable low
    pe = 1'b0;
    instr(2'b01, 7'd5, 1, 1, 16'h7777);
    no_prog("R7 no programming with pe low");
    pe = 1'b1;
    rd(5, 1, 1, 0, "R7 blocked write left word");

    // R13 instruction during busy is ignored
    instr(2'b01, 7'd7, 1, 1, 16'h1111);
    cs_up();
    send_hdr(2'b00, subf(2'b00, 1), 1, 0, "");
    cs_down();
    poll_ready();
    mdl[14] = 8'h11; mdl[15] = 8'h11;
    instr(2'b01, 7'd8, 1, 1, 16'h2222);
    poll_ready();
    mdl[16] = 8'h22; mdl[17] = 8'h22;
    rd(7, 2, 1, 0, "R13 disable during busy ignored");

    // R8 erase
    instr(2'b11, 7'd3, 1, 0, 16'h0);
    wait_timed(TWD, "R12 erase time");
    mdl[6] = 8'hFF; mdl[7] = 8'hFF;
    rd(3, 1, 1, 0, "R8 erased word");

    // R10 write-all
    instr(2'b00, subf(2'b01, 1), 1, 1, 16'h5AA5);
    wait_timed(TWR, "R12 write-all time");
    for (int i = 0; i < 64; i++) mdl[i] = (i % 2 == 0) ? 8'h5A : 8'hA5;
    rd(0, 3, 1, 0, "R10 write-all low words");
    rd(31, 1, 1, 0, "R10 write-all last word");

    // R9 erase-all
    instr(2'b00, subf(2'b10, 1), 1, 0, 16'h0);
    wait_timed(TER, "R12 erase-all time");
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    rd(10, 2, 1, 0, "R9 erase-all");

    // R6 disable blocks again
    instr(2'b00, subf(2'b00, 1), 1, 0, 16'h0);
    instr(2'b01, 7'd2, 1, 1, 16'h1357);
    no_prog("R6 no programming after disable");
    rd(2, 1, 1, 0, "R6 write after disable ignored");

    // R4 byte mode
    instr(2'b00, subf(2'b11, 1), 1, 0, 16'h0);
    org = 1'b0;
    instr(2'b01, 7'd6, 0, 1, 16'h0012);
    poll_ready();
    instr(2'b01, 7'd7, 0, 1, 16'h0034);
    poll_ready();
    instr(2'b01, 7'd63, 0, 1, 16'h003C);
    wait_timed(TWD, "R12 byte write time");
    mdl[6] = 8'h12; mdl[7] = 8'h34; mdl[63] = 8'h3C;
    rd(62, 3, 0, 0, "R4 R5 byte sequential wrap");
    org = 1'b1;
    rd(3, 1, 1, 0, "R4 byte order in word view");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule